// File: doc/BRIEF.md
# Paged Address Translator with Translation Cache

This block turns 32-bit linear addresses into physical addresses for a processor core. A request carries a linear address and is accepted on a valid/ready handshake. The paging-enable input is sampled with the request. When paging is off, the address is returned unchanged. When paging is on, the upper 20 bits of the address (the virtual page number) are looked up in a 32-entry fully associative translation cache. A hit returns the physical address in the next cycle.

On a miss the block walks a two-level page table through a single memory read port. The ten top bits of the address select a 4-byte entry in the page directory. That entry gives the base of a page table. The next ten bits select a 4-byte entry in that table, which gives the 4 KB frame base. The low twelve bits pass through as the byte offset. A missing entry at either level ends the walk with a page fault. A successful walk fills the cache, replacing entries round-robin.

Software points the walker at a directory by writing the directory base register. Every such write invalidates the whole cache.

Top module: `pgx_translate`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0, mem_req_valid is 0 and the cache holds no valid entry, so the first paging-enabled request performs a walk.
- R2: A request accepted with pg_en = 0 produces rsp_valid = 1 on the next cycle, with rsp_paddr equal to the linear address and rsp_fault = 0. No memory read is issued.
- R3: A walk issues exactly two reads, in this order. The directory read is at {base[31:12], la[31:22], 2'b00}, where base is the directory base register value when the request was accepted. The table read is at {dir_entry[31:12], la[21:12], 2'b00}.
- R4: On a walk whose table entry has bit 0 (present) set, rsp_paddr = {table_entry[31:12], la[11:0]} and rsp_fault = 0. rsp_valid rises in the cycle after the table read data arrives. Entry bits 11:1 have no effect.
- R5: If the directory entry has bit 0 clear, the walk stops after that one read. The response has rsp_fault = 1 and rsp_paddr = 0, and nothing is written into the cache.
- R6: If the table entry has bit 0 clear, the response has rsp_fault = 1 and rsp_paddr = 0, and nothing is written into the cache.
- R7: After a successful walk, a request to any offset in the same page hits the cache. It returns the physical address on the next cycle with no memory read.
- R8: Writing the directory base register (dbr_we = 1) invalidates every cache entry. req_ready is 0 in the cycle of the write.
- R9: The cache holds 32 translations. A new fill replaces the entries in round-robin order starting from slot 0 after a flush, so the 33rd fill evicts the first one.
- R10: If the directory base is written while a walk is in progress, that walk still returns its result but does not fill the cache.
- R11: While mem_req_valid is 1 and mem_req_ready is 0, mem_req_valid stays 1 and mem_req_addr stays unchanged on the next cycle.
- R12: req_ready is 0 from the cycle after a miss is accepted until the cycle in which its response is presented, and is 1 in that response cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pg_en | input | 1 | Paging enable, sampled with each accepted request |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 32 | Linear address of the request |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_paddr | output | 32 | Physical address (0 on fault) |
| rsp_fault | output | 1 | Page fault indication |
| dbr_we | input | 1 | Write strobe for the directory base register |
| dbr_wdata | input | 32 | New directory base (bits 31:12 used) |
| mem_req_valid | output | 1 | Table read request valid |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 32 | Byte address of the table entry to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Entry read from memory |

## Verification
The bench targets these corner cases:
- Faults at both levels, each sent twice. A design that cached a faulting translation would answer the second attempt without any memory read.
- A request to a page just translated, but with paging disabled. A design that consulted the cache in bypass mode would return the cached frame instead of the linear address.
- A base rewrite in the middle of a walk, followed by the same request. Without the stale-fill guard this request would hit a translation that belongs to an old table.
- Thirty-three fills followed by probes of the oldest, third and newest pages. These catch a wrong eviction order.
- A memory port that stalls its ready signal. This catches an address that moves or a read that is issued twice.

// File: rtl/xlt_pkg.sv
package xlt_pkg;
  localparam int ADDR_W = 32;
  localparam int OFF_W  = 12;
  localparam int IDX_W  = 10;
  localparam int PFN_W  = ADDR_W - OFF_W;

  typedef enum logic [2:0] {
    WS_IDLE  = 3'd0,
    WS_DREQ  = 3'd1,
    WS_DWAIT = 3'd2,
    WS_TREQ  = 3'd3,
    WS_TWAIT = 3'd4
  } walk_st_e;
endpackage

// File: rtl/xlt_cache.sv
module xlt_cache
  import xlt_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int TAG_W   = PFN_W,
  parameter int DATA_W  = PFN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TAG_W-1:0]  lk_tag,
  output logic              lk_hit,
  output logic [DATA_W-1:0] lk_data,
  input  logic              flush,
  input  logic              fill_en,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic [DATA_W-1:0] fill_data
);
  localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] vld_q, vld_d, hit_vec;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [DATA_W-1:0]  dat_q [ENTRIES];
  logic [PTR_W-1:0]   rr_q, rr_d;
  logic               wr_go;

  // parallel tag compare, one comparator per slot
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_vec[g] = vld_q[g] && (tag_q[g] == lk_tag);
  end

  assign lk_hit = |hit_vec;

  always_comb begin
    lk_data = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec[i]) lk_data = lk_data | dat_q[i];
    end
  end

  assign wr_go = fill_en && !flush;

  // next state: flush wins over fill, pointer restarts at slot 0
  always_comb begin
    vld_d = vld_q;
    rr_d  = rr_q;
    if (flush) begin
      vld_d = '0;
      rr_d  = '0;
    end else if (fill_en) begin
      vld_d[rr_q] = 1'b1;
      rr_d        = (rr_q == LAST) ? '0 : rr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      rr_q  <= '0;
    end else begin
      vld_q <= vld_d;
      rr_q  <= rr_d;
    end
  end

  // payload storage, no reset, written only under its enable
  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (wr_go && (rr_q == PTR_W'(i))) begin
        tag_q[i] <= fill_tag;
        dat_q[i] <= fill_data;
      end
    end
  end

  AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec)); // R7

  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (vld_q == '0)); // R8
endmodule

// File: rtl/xlt_walker.sv
module xlt_walker
  import xlt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_la,
  input  logic [PFN_W-1:0]  dir_base,
  input  logic              flush_evt,
  output logic              busy,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [ADDR_W-1:0] mem_rsp_data,
  output logic              done,
  output logic              done_fault,
  output logic [ADDR_W-1:0] done_paddr,
  output logic              fill_en,
  output logic [PFN_W-1:0]  fill_tag,
  output logic [PFN_W-1:0]  fill_data
);
  walk_st_e          st_q, st_d;
  logic [ADDR_W-1:0] la_q;
  logic [PFN_W-1:0]  db_q;
  logic [PFN_W-1:0]  tb_q;
  logic              stale_q, stale_d;
  logic              ld_req, ld_tbl;
  logic              present;
  logic              attr_unused;

  assign present     = mem_rsp_data[0];
  assign attr_unused = ^mem_rsp_data[OFF_W-1:1];

  assign ld_req = (st_q == WS_IDLE) && start;
  assign ld_tbl = (st_q == WS_DWAIT) && mem_rsp_valid && present;

  always_comb begin
    st_d       = st_q;
    stale_d    = stale_q;
    done       = 1'b0;
    done_fault = 1'b0;
    fill_en    = 1'b0;
    case (st_q)
      WS_IDLE: begin
        if (start) begin
          st_d    = WS_DREQ;
          stale_d = 1'b0;
        end
      end
      WS_DREQ:  if (mem_req_ready) st_d = WS_DWAIT;
      WS_DWAIT: begin
        if (mem_rsp_valid) begin
          if (present) begin
            st_d = WS_TREQ;
          end else begin
            done       = 1'b1;
            done_fault = 1'b1;
            st_d       = WS_IDLE;
          end
        end
      end
      WS_TREQ:  if (mem_req_ready) st_d = WS_TWAIT;
      WS_TWAIT: begin
        if (mem_rsp_valid) begin
          done = 1'b1;
          st_d = WS_IDLE;
          if (present) fill_en = !stale_q && !flush_evt;
          else         done_fault = 1'b1;
        end
      end
      default: st_d = WS_IDLE;
    endcase
    if ((st_q != WS_IDLE) && flush_evt) stale_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= WS_IDLE;
      stale_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      stale_q <= stale_d;
    end
  end

  always_ff @(posedge clk) begin
    if (ld_req) begin
      la_q <= start_la;
      db_q <= dir_base;
    end
    if (ld_tbl) tb_q <= mem_rsp_data[ADDR_W-1:OFF_W];
  end

  assign busy          = (st_q != WS_IDLE);
  assign mem_req_valid = (st_q == WS_DREQ) || (st_q == WS_TREQ);

  always_comb begin
    mem_req_addr = '0;
    if (st_q == WS_DREQ)
      mem_req_addr = {db_q, la_q[ADDR_W-1:ADDR_W-IDX_W], 2'b00};
    else if (st_q == WS_TREQ)
      mem_req_addr = {tb_q, la_q[OFF_W+IDX_W-1:OFF_W], 2'b00};
  end

  assign done_paddr = done_fault ? '0 : {mem_rsp_data[ADDR_W-1:OFF_W], la_q[OFF_W-1:0]};
  assign fill_tag   = la_q[ADDR_W-1:OFF_W];
  assign fill_data  = mem_rsp_data[ADDR_W-1:OFF_W];

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R11

  AST_TBL_AFTER_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == WS_TREQ) |-> ($past(st_q) == WS_DWAIT || $past(st_q) == WS_TREQ)); // R3

  AST_DIR_FAULT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == WS_DWAIT && mem_rsp_valid && !present) |=> !mem_req_valid); // R5
endmodule

// File: rtl/pgx_translate.sv
module pgx_translate
  import xlt_pkg::*;
#(
  parameter int ENTRIES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pg_en,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_paddr,
  output logic              rsp_fault,
  input  logic              dbr_we,
  input  logic [ADDR_W-1:0] dbr_wdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [ADDR_W-1:0] mem_rsp_data
);
  logic              rst_s0, rst_s1, rst_int_n;
  logic [PFN_W-1:0]  dbr_q;
  logic              dbr_unused;
  logic              accept, acc_byp, acc_hit, acc_miss;
  logic              c_hit;
  logic [PFN_W-1:0]  c_pfn;
  logic              wk_busy, wk_done, wk_fault, wk_fill;
  logic [ADDR_W-1:0] wk_paddr;
  logic [PFN_W-1:0]  wk_tag, wk_data;
  logic              rsp_ld;
  logic [ADDR_W-1:0] pa_d, pa_q;
  logic              flt_d, flt_q, rv_q;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s0 <= 1'b0;
      rst_s1 <= 1'b0;
    end else begin
      rst_s0 <= 1'b1;
      rst_s1 <= rst_s0;
    end
  end
  assign rst_int_n = rst_s1;

  assign dbr_unused = ^dbr_wdata[OFF_W-1:0];

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  dbr_q <= '0;
    else if (dbr_we) dbr_q <= dbr_wdata[ADDR_W-1:OFF_W];
  end

  assign req_ready = rst_int_n && !wk_busy && !dbr_we;
  assign accept    = req_valid && req_ready;
  assign acc_byp   = accept && !pg_en;
  assign acc_hit   = accept && pg_en && c_hit;
  assign acc_miss  = accept && pg_en && !c_hit;

  xlt_cache #(.ENTRIES(ENTRIES), .TAG_W(PFN_W), .DATA_W(PFN_W)) u_cache (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .lk_tag    (req_addr[ADDR_W-1:OFF_W]),
    .lk_hit    (c_hit),
    .lk_data   (c_pfn),
    .flush     (dbr_we),
    .fill_en   (wk_fill),
    .fill_tag  (wk_tag),
    .fill_data (wk_data)
  );

  xlt_walker u_walk (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .start         (acc_miss),
    .start_la      (req_addr),
    .dir_base      (dbr_q),
    .flush_evt     (dbr_we),
    .busy          (wk_busy),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .done          (wk_done),
    .done_fault    (wk_fault),
    .done_paddr    (wk_paddr),
    .fill_en       (wk_fill),
    .fill_tag      (wk_tag),
    .fill_data     (wk_data)
  );

  // response next state
  assign rsp_ld = acc_byp || acc_hit || wk_done;

  always_comb begin
    pa_d  = pa_q;
    flt_d = flt_q;
    if (acc_byp) begin
      pa_d  = req_addr;
      flt_d = 1'b0;
    end else if (acc_hit) begin
      pa_d  = {c_pfn, req_addr[OFF_W-1:0]};
      flt_d = 1'b0;
    end else if (wk_done) begin
      pa_d  = wk_paddr;
      flt_d = wk_fault;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) rv_q <= 1'b0;
    else            rv_q <= rsp_ld;
  end

  always_ff @(posedge clk) begin
    if (rsp_ld) begin
      pa_q  <= pa_d;
      flt_q <= flt_d;
    end
  end

  assign rsp_valid = rv_q;
  assign rsp_paddr = pa_q;
  assign rsp_fault = flt_q;

  AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (!rst_int_n)
    acc_byp |=> (rsp_valid && !rsp_fault && rsp_paddr == $past(req_addr))); // R2

  AST_HIT_NEXT: assert property (@(posedge clk) disable iff (!rst_int_n)
    acc_hit |=> (rsp_valid && !rsp_fault && !mem_req_valid)); // R7

  AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rsp_valid && rsp_fault) |-> (rsp_paddr == '0)); // R6

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_int_n)
    mem_req_valid |-> !req_ready); // R12
endmodule

// File: tb/tb_pgx_translate.sv
`timescale 1ns/1ps
module tb_pgx_translate;
  logic        clk, rst_n, pg_en, req_valid, req_ready;
  logic [31:0] req_addr, rsp_paddr, dbr_wdata, mem_req_addr, mem_rsp_data;
  logic        rsp_valid, rsp_fault, dbr_we, mem_req_valid, mem_req_ready, mem_rsp_valid;

  int tests = 0, fails = 0;
  logic [31:0] cur_dbr;
  logic [31:0] rd_log [256];
  int rd_cnt = 0;
  bit stall_mode = 0;
  int stall_ctr = 0;
  bit pend = 0, hold_pend = 0;
  logic [31:0] pend_addr, held_addr;
  int hold_err = 0, hold_seen = 0;

  pgx_translate dut (
    .clk(clk), .rst_n(rst_n), .pg_en(pg_en), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
    .dbr_we(dbr_we), .dbr_wdata(dbr_wdata), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data));

  initial clk = 0;
  always #4 clk = ~clk;

  // packing: [35]=pg_en, [34:3]=linear address, [2:1]=expected reads, [0]=expected fault
  localparam int NVEC = 10;
  localparam logic [35:0] VEC [NVEC] = '{
    {1'b0, 32'hDEAD_BEEF, 2'd0, 1'b0},
    {1'b1, 32'h0040_2345, 2'd2, 1'b0},
    {1'b1, 32'h0040_2FFF, 2'd0, 1'b0},
    {1'b1, 32'hFFC0_5010, 2'd1, 1'b1},
    {1'b1, 32'hFFC0_5010, 2'd1, 1'b1},
    {1'b1, 32'h00FF_F0AB, 2'd2, 1'b1},
    {1'b1, 32'h00FF_F0AB, 2'd2, 1'b1},
    {1'b0, 32'h0040_2999, 2'd0, 1'b0},
    {1'b1, 32'h556A_A777, 2'd2, 1'b0},
    {1'b1, 32'h556A_A000, 2'd0, 1'b0}
  };

  function automatic logic [31:0] mem_model(input logic [31:0] a);
    logic [9:0] d, t;
    if (a[31:12] == cur_dbr[31:12]) begin
      d = a[11:2];
      return (d == 10'h3FF) ? 32'h0 : {20'h20000 + {10'd0, d}, 12'h0E1};
    end else if (a[31:22] == 10'h080) begin
      d = a[21:12];
      t = a[11:2];
      return (t == 10'h3FF) ? 32'h0 : {20'h80000 ^ {d, t}, 12'h0E7};
    end
    return 32'h0;
  endfunction

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  // memory responder: one-cycle read latency, optional ready stalls
  initial begin
    mem_req_ready = 0; mem_rsp_valid = 0; mem_rsp_data = 0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 0;
      if (pend) begin
        mem_rsp_valid = 1;
        mem_rsp_data  = mem_model(pend_addr);
        pend = 0;
      end
      if (hold_pend) begin
        hold_seen++;
        if (!(mem_req_valid && mem_req_addr == held_addr)) hold_err++;
        hold_pend = 0;
      end
      stall_ctr++;
      mem_req_ready = stall_mode ? (stall_ctr % 3 == 0) : 1'b1;
      if (mem_req_valid && mem_req_ready) begin
        rd_log[rd_cnt % 256] = mem_req_addr;
        rd_cnt++;
        pend = 1;
        pend_addr = mem_req_addr;
      end else if (mem_req_valid) begin
        hold_pend = 1;
        held_addr = mem_req_addr;
      end
    end
  end

  task automatic xlate(input logic pg, input logic [31:0] la, input int exp_reads, input logic exp_flt);
    int base, lat;
    logic [31:0] exp_pa;
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_addr = la; pg_en = pg; base = rd_cnt;
    @(negedge clk);
    req_valid = 0; lat = 1;
    if (exp_reads > 0)
      chk(!rsp_valid && !req_ready, "R12 ready low during walk", {31'd0, req_ready}, 32'd0);
    while (!rsp_valid && lat < 60) begin @(negedge clk); lat++; end
    if (!pg)          exp_pa = la;
    else if (exp_flt) exp_pa = 32'h0;
    else              exp_pa = {20'h80000 ^ {la[31:22], la[21:12]}, la[11:0]};
    chk(rsp_valid, "R4 response present", {31'd0, rsp_valid}, 32'd1);
    chk(rsp_paddr == exp_pa, !pg ? "R2 passthrough paddr" : (exp_flt ? "R5 R6 fault paddr" : "R4 paddr"),
        rsp_paddr, exp_pa);
    chk(rsp_fault == exp_flt, "R5 R6 fault flag", {31'd0, rsp_fault}, {31'd0, exp_flt});
    chk(rd_cnt - base == exp_reads, "R7 R3 memory read count", rd_cnt - base, exp_reads);
    if (exp_reads == 0) chk(lat == 1, "R7 R2 one-cycle latency", lat, 1);
    else chk(req_ready, "R12 ready back with response", {31'd0, req_ready}, 32'd1);
    if (exp_reads >= 1)
      chk(rd_log[base % 256] == {cur_dbr[31:12], la[31:22], 2'b00}, "R3 directory read address",
          rd_log[base % 256], {cur_dbr[31:12], la[31:22], 2'b00});
    if (exp_reads >= 2)
      chk(rd_log[(base + 1) % 256] == {20'h20000 + {10'd0, la[31:22]}, la[21:12], 2'b00},
          "R3 table read address", rd_log[(base + 1) % 256],
          {20'h20000 + {10'd0, la[31:22]}, la[21:12], 2'b00});
  endtask

  task automatic write_dbr(input logic [31:0] v);
    @(negedge clk);
    dbr_we = 1; dbr_wdata = v;
    #1;
    chk(!req_ready, "R8 ready low on base write", {31'd0, req_ready}, 32'd0);
    @(negedge clk);
    dbr_we = 0; cur_dbr = v;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int base, lat;
    rst_n = 0; pg_en = 0; req_valid = 0; req_addr = 0; dbr_we = 0; dbr_wdata = 0;
    cur_dbr = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(req_ready && !rsp_valid && !mem_req_valid, "R1 reset state",
        {29'd0, req_ready, rsp_valid, mem_req_valid}, 32'h4);
    write_dbr(32'h0010_0000);

    // vector table
    for (int i = 0; i < NVEC; i++) begin
      logic [35:0] v;
      v = VEC[i];
      xlate(v[35], v[34:3], int'(v[2:1]), v[0]);
    end

    // R8: flush by base write, then the cached page walks again with the new base
    write_dbr(32'h0030_0000);
    xlate(1'b1, 32'h0040_2345, 2, 1'b0);
    xlate(1'b1, 32'h0040_2001, 0, 1'b0);

    // R10: base write during a walk suppresses the fill
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_addr = {10'd8, 10'd1, 12'h010}; pg_en = 1; base = rd_cnt;
    @(negedge clk);
    req_valid = 0;
    while (rd_cnt < base + 2) @(negedge clk);
    dbr_we = 1; dbr_wdata = cur_dbr;
    @(negedge clk);
    dbr_we = 0; lat = 0;
    while (!rsp_valid && lat < 60) begin @(negedge clk); lat++; end
    chk(rsp_valid && !rsp_fault && rsp_paddr == {20'h80000 ^ {10'd8, 10'd1}, 12'h010},
        "R10 result delivered despite flush", rsp_paddr, {20'h80000 ^ {10'd8, 10'd1}, 12'h010});
    xlate(1'b1, {10'd8, 10'd1, 12'h010}, 2, 1'b0);

    // R9: round-robin replacement over 32 slots
    write_dbr(cur_dbr);
    for (int t = 0; t < 33; t++) xlate(1'b1, {10'd20, 10'(t), 12'h004}, 2, 1'b0);
    xlate(1'b1, {10'd20, 10'd2, 12'h100}, 0, 1'b0);
    xlate(1'b1, {10'd20, 10'd32, 12'h100}, 0, 1'b0);
    xlate(1'b1, {10'd20, 10'd0, 12'h100}, 2, 1'b0);

    // R11: stalled memory request holds valid and address
    stall_mode = 1;
    xlate(1'b1, {10'd7, 10'd9, 12'h3C0}, 2, 1'b0);
    stall_mode = 0;
    chk(hold_seen > 0 && hold_err == 0, "R11 request held while stalled", hold_err, 0);

    repeat (3) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule